// File: doc/BRIEF.md
# Register-Exchange Survivor Memory

This block is the survivor store of a hard-decision Viterbi decoder whose constraint length can be switched between 3, 5 and 7. On each accepted trellis step the add-compare-select stage supplies one decision bit per state. Every state keeps a row of bits that records the decoded history of the surviving path ending in that state. On a step, each active row is replaced by the row of the predecessor chosen by its decision. That copy is shifted one place towards the old end, and the state's own decoded bit is written at the young end.

The oldest column is reduced to one output bit by a vote across the active rows. This gives a usable bit even when the surviving paths have not yet merged into a common trunk. A synchronization pulse at the start of a burst empties the store. The output is flagged valid only once enough steps have passed to fill every column. Metric arithmetic lives outside this block.

Top module: `survivor_exchange`

## Requirements
- R1: After reset, and in the cycle after a synchronization pulse, every row is cleared to zero, `outValid` is 0 and `decodedBit` is 0.
- R2: `outValid` rises in the cycle that follows the 30th accepted step after synchronization (depth 5*(K-1) for K=7), and it stays high until the next synchronization.
- R3: On an accepted step, the row of active state s (S = 2^(K-1) states) takes the old row of state (2s) mod S when its decision is 0, or of state (2s+1) mod S when its decision is 1. That copy moves one column towards the oldest end, and column 0 receives bit K-2 of s.
- R4: `decodedBit` is 1 when more than half of the active rows hold 1 in their oldest column, and 0 when fewer than half do.
- R5: When exactly half of the active rows hold 1 in the oldest column, `decodedBit` equals the oldest bit of state 0.
- R6: `kSel` encodes the constraint length: 0 gives K=3, 1 gives K=5, and 2 or 3 give K=7. Decision bits at positions of S and above have no effect on the output.
- R7: When `stepEn` is 0 and `sync` is 0, the store holds, so `decodedBit` and `outValid` are unchanged while `kSel` is unchanged.
- R8: When `sync` and `stepEn` are both high, the synchronization wins: the store clears and the step is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sync | input | 1 | Start-of-burst pulse; clears the store |
| stepEn | input | 1 | Accept the decision word this cycle |
| kSel | input | 2 | Constraint-length select |
| decisions | input | 64 | One decision bit per trellis state, state s at bit s |
| decodedBit | output | 1 | Vote over the oldest column |
| outValid | output | 1 | Store is full since the last synchronization |

## Verification
Random decision words at each constraint length exercise the predecessor wiring and the head-bit insertion. A wrong shift amount or a wrong predecessor appears as a mismatch in the voted bit against the reference. All-zero and all-one decision streams make the paths converge and give fixed, predictable histories. The short-constraint runs, with random upper decision bits, show whether rows outside the active range are leaking into the vote. Steps with `stepEn` gated at random, and a pulse that raises `sync` together with `stepEn`, separate hold behaviour, fill counting and clear priority. The four-state runs often produce even splits, which exercise the tie rule.

// File: rtl/svx_pkg.sv
package svx_pkg;
  localparam int K_LIM = 7;
  localparam int LOGW  = $clog2(K_LIM);

  typedef struct packed {
    logic            clearRows;
    logic            shiftRows;
    logic [LOGW-1:0] memLog;    // K-1 of the selected code
  } svStrobe_t;
endpackage

// File: rtl/svx_ctrl.sv
module svx_ctrl
  import svx_pkg::*;
#(
  parameter int MAX_K = K_LIM
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sync,
  input  logic      stepEn,
  input  logic [1:0] kSel,
  output svStrobe_t strobe,
  output logic      outValid
);
  localparam int DEPTH = 5 * (MAX_K - 1);
  localparam int CW    = $clog2(DEPTH + 1);

  logic [CW-1:0] fillCnt;

  always_comb begin
    strobe.clearRows = sync;
    strobe.shiftRows = stepEn & ~sync;
    unique case (kSel)
      2'd0:    strobe.memLog = LOGW'(2);
      2'd1:    strobe.memLog = LOGW'(4);
      default: strobe.memLog = LOGW'(MAX_K - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               fillCnt <= '0;
    else if (sync)                           fillCnt <= '0;
    else if (stepEn && fillCnt != CW'(DEPTH)) fillCnt <= fillCnt + CW'(1);
  end

  assign outValid = (fillCnt == CW'(DEPTH));
endmodule

// File: rtl/svx_datapath.sv
module svx_datapath
  import svx_pkg::*;
#(
  parameter  int MAX_K = K_LIM,
  localparam int NS    = 1 << (MAX_K - 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  svStrobe_t     strobe,
  input  logic [NS-1:0] decisions,
  output logic          decodedBit
);
  localparam int DEPTH = 5 * (MAX_K - 1);
  localparam int SW    = MAX_K - 1;

  logic [DEPTH-1:0] rows     [NS];
  logic [DEPTH-1:0] nextRows [NS];
  logic [NS-1:0]    isActive;

  for (genvar s = 0; s < NS; s++) begin : g_row
    logic [SW-1:0] mask, pLo, pHi;
    logic          head;
    always_comb begin
      mask = SW'((32'd1 << strobe.memLog) - 32'd1);
      pLo  = SW'(2 * s) & mask;
      pHi  = pLo | SW'(1);
      head = ((s >> (int'(strobe.memLog) - 1)) & 1) != 0;
    end
    assign isActive[s] = s < int'(32'd1 << strobe.memLog);
    assign nextRows[s] = {decisions[s] ? rows[pHi][DEPTH-2:0] : rows[pLo][DEPTH-2:0], head};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NS; s++) rows[s] <= '0;
    end else if (strobe.clearRows) begin
      for (int s = 0; s < NS; s++) rows[s] <= '0;
    end else if (strobe.shiftRows) begin
      for (int s = 0; s < NS; s++)
        if (isActive[s]) rows[s] <= nextRows[s];
    end
  end

  // vote over the oldest column of the active rows
  always_comb begin
    int ones;
    int act;
    ones = 0;
    act  = 0;
    for (int s = 0; s < NS; s++) begin
      if (isActive[s]) begin
        act  = act + 1;
        ones = ones + int'(rows[s][DEPTH-1]);
      end
    end
    if (2 * ones > act)       decodedBit = 1'b1;
    else if (2 * ones == act) decodedBit = rows[0][DEPTH-1];
    else                      decodedBit = 1'b0;
  end
endmodule

// File: rtl/survivor_exchange.sv
module survivor_exchange
  import svx_pkg::*;
#(
  parameter  int MAX_K = K_LIM,
  localparam int NS    = 1 << (MAX_K - 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sync,
  input  logic          stepEn,
  input  logic [1:0]    kSel,
  input  logic [NS-1:0] decisions,
  output logic          decodedBit,
  output logic          outValid
);
  svStrobe_t strobe;

  svx_ctrl #(.MAX_K(MAX_K)) i_ctrl (
    .clk(clk), .rstN(rstN), .sync(sync), .stepEn(stepEn), .kSel(kSel),
    .strobe(strobe), .outValid(outValid)
  );

  svx_datapath #(.MAX_K(MAX_K)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .decisions(decisions),
    .decodedBit(decodedBit)
  );
endmodule

// File: rtl/survivor_exchange_chk.sv
module survivor_exchange_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sync,
  input logic       stepEn,
  input logic [1:0] kSel,
  input logic       decodedBit,
  input logic       outValid
);
  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    sync |=> (!outValid && !decodedBit));  // R1
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !sync) |=> outValid);  // R2
  AST_VALID_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(stepEn));  // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stepEn && !sync) |=> ($stable(kSel) -> ($stable(decodedBit) && $stable(outValid))));  // R7
  AST_SYNC_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (sync && stepEn) |=> !outValid);  // R8
endmodule

bind survivor_exchange survivor_exchange_chk i_chk (.*);

// File: tb/test_survivor_exchange.sv
`timescale 1ns/1ps
module test_survivor_exchange;
  localparam int DEPTH = 30;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sync = 1'b0;
  logic        stepEn = 1'b0;
  logic [1:0]  kSel = 2'd2;
  logic [63:0] decisions = '0;
  logic        decodedBit, outValid;

  int checks = 0, fails = 0, tieSeen = 0;
  bit done = 0;
  int hist [64][DEPTH];
  int fill = 0;

  always #4 clk = ~clk;

  survivor_exchange i_survivor_exchange (
    .clk(clk), .rstN(rstN), .sync(sync), .stepEn(stepEn), .kSel(kSel),
    .decisions(decisions), .decodedBit(decodedBit), .outValid(outValid)
  );

  function automatic int logOf(input logic [1:0] k);
    return (k == 2'd0) ? 2 : (k == 2'd1) ? 4 : 6;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep(input bit sy, input bit st, input logic [63:0] d, input logic [1:0] k);
    int tmp [64][DEPTH];
    int l, nS, p;
    if (sy) begin
      foreach (hist[s, c]) hist[s][c] = 0;
      fill = 0;
    end else if (st) begin
      l  = logOf(k);
      nS = 1 << l;
      tmp = hist;
      for (int s = 0; s < nS; s++) begin
        p = ((2 * s) % nS) + int'(d[s]);
        for (int c = DEPTH - 1; c > 0; c--) hist[s][c] = tmp[p][c-1];
        hist[s][0] = (s >> (l - 1)) & 1;
      end
      if (fill < DEPTH) fill++;
    end
  endtask

  task automatic compare(input string tag);
    int nS, ones, expBit;
    nS = 1 << logOf(kSel);
    ones = 0;
    for (int s = 0; s < nS; s++) ones += hist[s][DEPTH-1];
    if (2 * ones > nS) expBit = 1;
    else if (2 * ones == nS) begin
      expBit = hist[0][DEPTH-1];
      if (fill >= DEPTH) tieSeen++;
    end else expBit = 0;
    chk(outValid === (fill >= DEPTH), {"R2 valid ", tag}, int'(outValid), int'(fill >= DEPTH));
    chk(decodedBit === expBit[0], {"R4 bit ", tag}, int'(decodedBit), expBit);
  endtask

  task automatic cyc(input bit sy, input bit st, input logic [63:0] d,
                     input logic [1:0] k, input string tag);
    sync = sy; stepEn = st; decisions = d; kSel = k;
    @(posedge clk);
    modelStep(sy, st, d, k);
    #2;
    compare(tag);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    foreach (hist[s, c]) hist[s][c] = 0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk(outValid === 1'b0, "R1 reset valid", int'(outValid), 0);
    chk(decodedBit === 1'b0, "R1 reset bit", int'(decodedBit), 0);
    rstN = 1'b1;
    @(posedge clk); #2;

    // R3 R4 K=7 random decisions; R2 valid edge counted each cycle
    cyc(1, 0, '0, 2'd2, "R1 sync");
    for (int i = 0; i < 80; i++) cyc(0, 1, rnd64(), 2'd2, "R3 K7 random");
    // R7 idle cycles with noisy decisions
    for (int i = 0; i < 10; i++) cyc(0, 0, rnd64(), 2'd2, "R7 idle");
    // R8 sync together with step
    cyc(1, 1, rnd64(), 2'd2, "R8 sync+step");
    chk(outValid === 1'b0, "R8 cleared", int'(outValid), 0);

    // R6 K=3 with random upper decisions; R5 ties frequent
    for (int i = 0; i < 120; i++) cyc(0, 1, rnd64(), 2'd0, "R6 K3 random");
    cyc(1, 0, '0, 2'd1, "R1 sync");
    // K=5 with gated steps
    for (int i = 0; i < 120; i++) cyc(0, ($urandom % 2) == 0, rnd64(), 2'd1, "R7 K5 gated");
    cyc(1, 0, '0, 2'd1, "R1 sync");
    for (int i = 0; i < 40; i++) cyc(0, 1, '1, 2'd1, "R3 K5 ones");
    cyc(1, 0, '0, 2'd2, "R1 sync");
    for (int i = 0; i < 40; i++) cyc(0, 1, '0, 2'd2, "R3 K7 zeros");
    // R6 code 3 behaves as K=7
    cyc(1, 0, '0, 2'd3, "R1 sync");
    for (int i = 0; i < 60; i++) cyc(0, 1, rnd64(), 2'd3, "R6 code3");
    // R2 exact fill edge
    cyc(1, 0, '0, 2'd2, "R1 sync");
    for (int i = 0; i < DEPTH - 1; i++) cyc(0, 1, rnd64(), 2'd2, "R2 fill");
    chk(outValid === 1'b0, "R2 before full", int'(outValid), 0);
    cyc(0, 1, rnd64(), 2'd2, "R2 fill");
    chk(outValid === 1'b1, "R2 at full", int'(outValid), 1);
    // R5 tie situations met during the four-state run
    chk(tieSeen > 0, "R5 tie exercised", tieSeen, 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule